// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This controller drives a 2M x 8 dynamic memory whose address pins are shared between a row phase and a column phase. A host presents a 21-bit byte address with a read or write request; the controller splits it into a 12-bit row (upper bits) and a 9-bit column (lower bits). It places the row on the shared pins and lowers the row strobe. It then places the column on the same pins and lowers the column strobe. Read data is captured and returned with a one-cycle valid pulse.

After a column access the row stays open, with the row strobe held low. A later request to the same row costs only a new column phase (page mode). A request to another row first closes the page and waits out a precharge. Separately, a free-running interval timer requests one row refresh per interval. The default interval is the 64 ms array period divided by 4096 rows, expressed in clocks. A refresh strobes the next row from a 12-bit wrapping counter with the column strobe held high. A pending refresh takes precedence over the host at the next access boundary and closes an open page.

All strobe timings are parameters in clock counts.

Top module: `dram_mux_ctrl`

## Requirements
- R1: Address bits [20:9] appear on `dram_addr` when `dram_ras_n` falls, and bits [8:0] appear on `dram_addr[8:0]` when `dram_cas_n` falls, for every host access.
- R2: `dram_cas_n` is low only while `dram_ras_n` is low, `dram_cas_n` is high whenever `dram_ras_n` falls, and the row strobe has been low for at least T_RCD clocks when the column strobe falls.
- R3: Each column strobe stays low for exactly T_CAS clocks.
- R4: Back-to-back requests to the open row are served with `dram_ras_n` held low: a burst of same-row accesses opens the row once, plus at most once more per refresh that interrupts it.
- R5: A request to a row other than the open one closes the page, and `dram_ras_n` is high for at least T_RP clocks before every falling edge, including the first one after reset.
- R6: For a write, `dram_we_n` is low and `dram_dq_oe` is high from at least one clock before `dram_cas_n` falls until it rises, with `dram_dq_out` carrying the data. Reads keep `dram_we_n` high.
- R7: For a read, the value on `dram_dq_in` in the last column-strobe cycle is returned on `rd_data`, and `rd_valid` is high for the single cycle in which `dram_cas_n` returns high. Results come back in request order.
- R8: A refresh holds `dram_ras_n` low for exactly T_REF clocks with `dram_cas_n` high throughout. The row shown is a counter that starts at 0 after reset and advances by one (mod 4096) per refresh.
- R9: Refreshes start at most a few clocks (under 12 with the default timings) away from every REF_INTERVAL-clock tick, even during an endless same-row stream. A pending refresh wins over a waiting host request and forces an open page closed.
- R10: While `rst_n` is low, all strobes are high, `dram_dq_oe`, `rd_valid` and `req_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present; held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address: [20:9] row, [8:0] column |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted at this clock edge |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 8 | Read result |
| dram_addr | output | 12 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
The assertions assume the host keeps `req_valid` and its request fields steady from the cycle they are raised until `req_ready` is seen. They also assume `dram_dq_in` is valid in the last column-strobe cycle. The stimulus changes request fields only half a cycle after an accepting edge. It never withdraws a request early. A behavioural memory model sets the read data half a cycle after the column strobe falls. That model also records strobe timings, latched rows and columns, and refresh rows, so each pin rule is judged from what the memory would see.

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl #(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 9,
  parameter int DW           = 8,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_REF        = 3,
  parameter int CLK_MHZ      = 50,
  parameter int REF_MS       = 64,
  parameter int REF_INTERVAL = CLK_MHZ * 1000 * REF_MS / (1 << ROW_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DW-1:0]          req_wdata,
  output logic                   req_ready,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_data,
  output logic [ROW_W-1:0]       dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic [DW-1:0]          dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DW-1:0]          dram_dq_in
);
  localparam int AW  = ROW_W + COL_W;
  localparam int CW  = $clog2(T_RCD + T_CAS + T_RP + T_REF + 1);
  localparam int RTW = $clog2(REF_INTERVAL + 1);

  typedef enum logic [2:0] {S_PRE, S_IDLE, S_ROW, S_COLSET, S_CAS, S_OPEN, S_REF} st_e;

  st_e              st;
  logic [CW-1:0]    cnt;
  logic [ROW_W-1:0] open_row, ref_row;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic [DW-1:0]    wd_q;
  logic [RTW-1:0]   tmr;
  logic             ref_pend;

  wire same_row  = req_addr[AW-1:COL_W] == open_row;
  wire col_phase = (st == S_COLSET) || (st == S_CAS);
  wire drive     = wr_q && col_phase;
  wire ref_due   = tmr == RTW'(REF_INTERVAL - 1);
  wire cnt_done  = cnt == '0;

  assign req_ready   = req_valid && !ref_pend && ((st == S_IDLE) || (st == S_OPEN && same_row));
  assign dram_ras_n  = (st == S_PRE) || (st == S_IDLE);
  assign dram_cas_n  = st != S_CAS;
  assign dram_we_n   = !drive;
  assign dram_dq_oe  = drive;
  assign dram_dq_out = wd_q;
  assign dram_addr   = col_phase ? ROW_W'(col_q) : (st == S_REF) ? ref_row : open_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_PRE;
      cnt      <= CW'(T_RP - 1);
      open_row <= '0;
      ref_row  <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      tmr      <= '0;
      ref_pend <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      tmr      <= ref_due ? '0 : tmr + RTW'(1);
      if (ref_due)
        ref_pend <= 1'b1;
      else if (st == S_IDLE && ref_pend)
        ref_pend <= 1'b0;
      if (req_ready) begin
        col_q <= req_addr[COL_W-1:0];
        wr_q  <= req_write;
        wd_q  <= req_wdata;
      end
      case (st)
        S_PRE:
          if (cnt_done) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        S_IDLE:
          if (ref_pend) begin
            st  <= S_REF;
            cnt <= CW'(T_REF - 1);
          end else if (req_valid) begin
            st       <= S_ROW;
            cnt      <= CW'(T_RCD - 1);
            open_row <= req_addr[AW-1:COL_W];
          end
        S_ROW:
          if (cnt_done) st <= S_COLSET;
          else cnt <= cnt - CW'(1);
        S_COLSET: begin
          st  <= S_CAS;
          cnt <= CW'(T_CAS - 1);
        end
        S_CAS:
          if (cnt_done) begin
            st <= S_OPEN;
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dram_dq_in;
            end
          end else cnt <= cnt - CW'(1);
        S_OPEN:
          if (ref_pend || (req_valid && !same_row)) begin
            st  <= S_PRE;
            cnt <= CW'(T_RP - 1);
          end else if (req_valid) st <= S_COLSET;
        S_REF:
          if (cnt_done) begin
            st      <= S_PRE;
            cnt     <= CW'(T_RP - 1);
            ref_row <= ref_row + ROW_W'(1);
          end else cnt <= cnt - CW'(1);
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic rd_valid
);
  logic [31:0] hi_c, lo_c, cs_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_c <= '0;
      lo_c <= '0;
      cs_c <= '0;
    end else begin
      hi_c <= ras_n ? hi_c + 32'd1 : '0;
      lo_c <= ras_n ? '0 : lo_c + 32'd1;
      cs_c <= cas_n ? '0 : cs_c + 32'd1;
    end
  end

  p_cas_inside_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_ras_before_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> cas_n);
  p_rcd_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> lo_c >= 32'(T_RCD));
  p_cas_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> cs_c == 32'(T_CAS));
  p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_c >= 32'(T_RP));
  p_we_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));
  p_rd_at_cas_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(cas_n));
endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .rd_valid(rd_valid));

// File: tb/dram_mux_ctrl_bench.sv
module dram_mux_ctrl_bench;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_REF = 3, RINT = 100, SLACK = 12;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [20:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, dq_oe;
  logic [7:0] rd_data, dq_out, dq_in = '0;
  logic [11:0] dram_addr;

  always #10 clk = ~clk;

  dram_mux_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF(T_REF), .REF_INTERVAL(RINT))
  u_dram_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b0, a[20:16]};
  endfunction

  logic [7:0] shadow [logic [20:0]];
  logic [7:0] mem [logic [20:0]];
  logic [7:0] exp_q[$];
  logic [20:0] addr_q[$];

  // memory model and pin monitor
  logic p_ras = 1, p_cas = 1, p_we = 1, cas_seen = 0, last_rd = 0;
  logic [11:0] m_row = '0;
  int hi_cnt = 0, lo_cnt = 0, cs_cnt = 0, opens = 0, refs = 0;
  int ras_fall_cyc = 0, last_ref_cyc = -1, exp_ref = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        chk(hi_cnt >= T_RP, "R5 precharge before RAS fall", hi_cnt, T_RP);
        chk(cas_n, "R2 CAS high at RAS fall", cas_n, 1);
        m_row = dram_addr;
        cas_seen = 0;
        ras_fall_cyc = cyc;
      end
      if (p_cas && !cas_n) begin
        logic [20:0] k;
        k = {m_row, dram_addr[8:0]};
        chk(!ras_n && lo_cnt >= T_RCD, "R2 RAS-to-CAS delay", lo_cnt, T_RCD);
        if (!cas_seen) opens++;
        cas_seen = 1;
        if (addr_q.size() == 0) chk(0, "R1 unexpected column access", 0, 1);
        else begin
          logic [20:0] ea;
          ea = addr_q.pop_front();
          chk(k == ea, "R1 row/column on pins", int'(k), int'(ea));
        end
        if (!we_n) begin
          chk(!p_we && dq_oe, "R6 WE and data before CAS", p_we, 0);
          mem[k] = dq_out;
          last_rd = 0;
        end else begin
          chk(!dq_oe, "R6 read keeps bus released", dq_oe, 0);
          dq_in <= mem.exists(k) ? mem[k] : dflt(k);
          last_rd = 1;
        end
      end
      if (!cas_n && !p_cas && !last_rd)
        chk(!we_n && dq_oe, "R6 write held during CAS", we_n, 0);
      if (!p_cas && cas_n) begin
        chk(cs_cnt == T_CAS, "R3 CAS width", cs_cnt, T_CAS);
        if (last_rd) chk(rd_valid, "R7 rd_valid as CAS rises", rd_valid, 1);
      end
      if (rd_valid) begin
        chk(!p_cas && cas_n, "R7 rd_valid only at CAS rise", p_cas, 0);
        if (exp_q.size() == 0) chk(0, "R7 unexpected read result", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R7 read data", rd_data, e);
        end
      end
      if (!p_ras && ras_n && !cas_seen) begin
        refs++;
        chk(m_row == 12'(exp_ref), "R8 refresh row", m_row, exp_ref);
        chk(lo_cnt == T_REF, "R8 refresh RAS width", lo_cnt, T_REF);
        exp_ref = (exp_ref + 1) % 4096;
        if (last_ref_cyc >= 0)
          chk((ras_fall_cyc - last_ref_cyc) <= RINT + SLACK &&
              (ras_fall_cyc - last_ref_cyc) >= RINT - SLACK,
              "R9 refresh spacing", ras_fall_cyc - last_ref_cyc, RINT);
        last_ref_cyc = ras_fall_cyc;
      end
      hi_cnt = ras_n ? hi_cnt + 1 : 0;
      lo_cnt = ras_n ? 0 : lo_cnt + 1;
      cs_cnt = cas_n ? 0 : cs_cnt + 1;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  task automatic xfer(bit wr, logic [20:0] a, logic [7:0] d);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    addr_q.push_back(a);
    if (wr) shadow[a] = d;
    else exp_q.push_back(shadow.exists(a) ? shadow[a] : dflt(a));
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic drain();
    req_valid = 0;
    for (int i = 0; i < 200 && (exp_q.size() != 0 || addr_q.size() != 0); i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 20000 && !done) begin
    done = 1;
    chk(0, "watchdog expired", cyc, 20000);
    summary();
  end

  initial begin
    int o0, r0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R10 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!dq_oe && !rd_valid && !req_ready, "R10 outputs idle in reset", {dq_oe, rd_valid, req_ready}, 0);
    rst_n = 1;
    @(negedge clk);

    xfer(1, 21'h0A5C3, 8'h5A);
    xfer(0, 21'h0A5C3, 0);
    xfer(0, 21'h13579, 0);
    drain();

    o0 = opens; r0 = refs;
    for (int i = 0; i < 4; i++) xfer(1, {12'h0AB, 9'(i * 3)}, 8'(8'h10 + i));
    for (int i = 0; i < 4; i++) xfer(0, {12'h0AB, 9'(i * 3)}, 0);
    drain();
    chk(opens - o0 >= 1 && opens - o0 <= 1 + refs - r0, "R4 page burst opens row once", opens - o0, 1);

    o0 = opens;
    xfer(0, {12'h111, 9'd5}, 0);
    xfer(0, {12'h222, 9'd5}, 0);
    xfer(0, {12'h333, 9'd5}, 0);
    drain();
    chk(opens - o0 == 3, "R5 row change reopens", opens - o0, 3);

    r0 = refs;
    for (int i = 0; i < 60; i++) xfer(0, {12'h155, 9'(i * 7)}, 0);
    drain();
    chk(refs - r0 >= 1, "R9 refresh breaks long page stream", refs - r0, 1);

    xfer(1, 21'h1FFFFF, 8'h3C);
    xfer(1, 21'h000000, 8'hC3);
    xfer(0, 21'h1FFFFF, 0);
    xfer(0, 21'h000000, 0);
    drain();

    r0 = refs;
    repeat (450) @(negedge clk);
    chk(refs - r0 >= 4, "R8 periodic refresh while idle", refs - r0, 4);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R7 all results returned", exp_q.size(), 0);

    done = 1;
    summary();
  end
endmodule